// File: doc/BRIEF.md
# SPI Status Flags and Interrupt Logic

This block holds the control and status state that sits beside an 8-bit SPI shift engine. It tracks four conditions: receive data register full, receive overflow, mode fault and transmit data register empty. It merges them into one CPU interrupt request, gated by three enables. The shift engine reports two strobes: a completed byte with its value, and the moment the transmit holding byte enters the shifter. The slave-select level arrives as a plain input.

The CPU reaches three byte-wide registers through a small address port. Address 0 is the control register: bit 0 module enable, bit 1 master mode, bit 2 receive interrupt enable, bit 3 transmit interrupt enable. Address 1 is the status/control register. Address 2 is the data register: a read returns the receive byte and a write loads the transmit byte. Address 3 reads as zero.

Flags clear through a two-step access: first a status read taken while the flag is set, then a data access. Dropping the module enable performs a partial reset. The flags return to their idle values, but the configuration is kept.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After a synchronous reset, the status register (address 1) reads 0x08 and the control register (address 0) reads 0x00. `irq` is 0 and `baud_sel` is 0.
- R2: While the module is enabled, a `rx_done` pulse sets receive-full (status bit 7). If receive-full was clear, the pulse also stores `rx_byte` in the receive data register, which reads back at address 2.
- R3: A `rx_done` pulse while receive-full is set, and not being cleared in that cycle, sets overflow (status bit 5). The receive data register then keeps its earlier byte and the new byte is lost.
- R4: Receive-full and overflow clear only through this sequence: a status read while the flag is set, then a data read. A data read with no such status read before it leaves both flags set.
- R5: Transmit-empty (status bit 3) is cleared by a data write while the module is enabled, and set again by `tx_load`. `tx_byte` presents the last byte written to address 2.
- R6: In the status register, only bits 6 (error interrupt enable), 2 (mode-fault detect enable) and 1:0 (baud select) are writable. Writes to bits 7, 5, 4 and 3 are ignored. `baud_sel` mirrors bits 1:0.
- R7: Mode fault (status bit 4) sets when all of these hold: the module is enabled, master mode is on, mode-fault detection is on, and `ss_n` is low.
- R8: Mode fault clears through this sequence: a status read while the flag is set, then a write to the control register. If the fault condition is still present, the flag stays set.
- R9: `irq` is the OR of three terms: receive-full with the receive enable, transmit-empty with the transmit enable, and overflow or mode fault with the error enable.
- R10: Clearing the module enable clears receive-full, overflow and mode fault, and sets transmit-empty. While disabled, `rx_done`, `tx_load` and data writes have no effect. Control and status configuration bits keep their values.
- R11: A data read that completes the clearing sequence, in the same cycle as `rx_done`, stores the new byte. Receive-full stays set and overflow stays clear. The read in that cycle returns the old byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data for the selected register (combinational) |
| rx_done | input | 1 | Shift engine finished receiving a byte |
| rx_byte | input | 8 | Byte received by the shift engine |
| tx_load | input | 1 | Transmit byte moved into the shifter |
| tx_byte | output | 8 | Transmit holding byte |
| ss_n | input | 1 | Slave-select level, active low |
| baud_sel | output | 2 | Master baud select |
| irq | output | 1 | Combined CPU interrupt request |

## Verification
The collision that matters is the completing data read landing in the same cycle as a new `rx_done`. Here the clearing path and the receive path both act on receive-full and on the receive data register. The bench arms the sequence with a status read, then issues the data read and the strobe together. It checks three things: the old byte is returned in that cycle, receive-full stays set without overflow, and a second clearing sequence returns the new byte. A second collision is tested as well: a control write that would clear mode fault while `ss_n` is still low. Here the flag must stay set.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
    localparam int BYTE_W = 8;
    localparam int BAUD_W = 2;
    localparam int CTRL_W = 4;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic txie;
        logic rxie;
        logic master;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic              errie;
        logic              mfen;
        logic [BAUD_W-1:0] baud;
    } stat_cfg_t;

    typedef struct packed {
        logic rxf;
        logic ovr;
        logic modf;
        logic txe;
    } flags_t;

    function automatic logic [BYTE_W-1:0] pack_status(flags_t f, stat_cfg_t c);
        return {f.rxf, c.errie, f.ovr, f.modf, f.txe, c.mfen, c.baud};
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctrl(ctrl_t c);
        return {{(BYTE_W-CTRL_W){1'b0}}, c};
    endfunction
endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_stat,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output stat_cfg_t         cfg_q,
    output logic              part_rst
);
    // partial reset acts on the same edge that drops the enable
    assign part_rst = wr_ctrl ? ~wdata[0] : ~ctrl_q.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_stat)
                cfg_q <= '{errie: wdata[6], mfen: wdata[2], baud: wdata[BAUD_W-1:0]};
        end
    end
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags
    import spi_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              part_rst,
    input  logic              rd_stat,
    input  logic              rd_data,
    input  logic              rx_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rxf,
    output logic              ovr,
    output logic [BYTE_W-1:0] rx_data
);
    logic rxf_arm, ovr_arm;
    logic rxf_clr, ovr_clr, accept, overrun;

    assign rxf_clr = rd_data & rxf_arm;
    assign ovr_clr = rd_data & ovr_arm;
    assign accept  = rx_done & (~rxf | rxf_clr);
    assign overrun = rx_done & rxf & ~rxf_clr;

    always_ff @(posedge clk) begin
        if (rst || part_rst) begin
            rxf     <= 1'b0;
            ovr     <= 1'b0;
            rxf_arm <= 1'b0;
            ovr_arm <= 1'b0;
        end else begin
            if (rd_stat) begin
                rxf_arm <= rxf;
                ovr_arm <= ovr;
            end else if (rd_data) begin
                rxf_arm <= 1'b0;
                ovr_arm <= 1'b0;
            end

            if (rx_done)
                rxf <= 1'b1;
            else if (rxf_clr)
                rxf <= 1'b0;

            if (overrun)
                ovr <= 1'b1;
            else if (ovr_clr)
                ovr <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rx_data <= '0;
        else if (accept && !part_rst)
            rx_data <= rx_byte;
    end
endmodule

// File: rtl/spi_fault_tx.sv
module spi_fault_tx
    import spi_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              part_rst,
    input  logic              mode_chk,
    input  logic              ss_n,
    input  logic              rd_stat,
    input  logic              wr_ctrl,
    input  logic              wr_data,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] wdata,
    output logic              modf,
    output logic              txe,
    output logic [BYTE_W-1:0] tx_byte
);
    logic modf_arm;
    logic fault;

    assign fault = mode_chk & ~ss_n;

    always_ff @(posedge clk) begin
        if (rst || part_rst) begin
            modf     <= 1'b0;
            modf_arm <= 1'b0;
            txe      <= 1'b1;
        end else begin
            if (rd_stat)
                modf_arm <= modf;
            else if (wr_ctrl)
                modf_arm <= 1'b0;

            if (fault)
                modf <= 1'b1;
            else if (wr_ctrl && modf_arm)
                modf <= 1'b0;

            // a fresh write waits in the holding register even if the old byte moves now
            if (wr_data)
                txe <= 1'b0;
            else if (tx_load)
                txe <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            tx_byte <= '0;
        else if (wr_data && !part_rst)
            tx_byte <= wdata;
    end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
    import spi_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    input  logic              rx_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              ss_n,
    output logic [BAUD_W-1:0] baud_sel,
    output logic              irq
);
    reg_sel_e          sel;
    logic              rd_stat, rd_data, wr_ctrl, wr_stat, wr_data;
    logic              part_rst, mode_chk;
    ctrl_t             ctrl_q;
    stat_cfg_t         cfg_q;
    flags_t            flg;
    logic [BYTE_W-1:0] rx_data;

    assign sel     = reg_sel_e'(cpu_addr);
    assign rd_stat = cpu_rd & (sel == REG_STAT);
    assign rd_data = cpu_rd & (sel == REG_DATA);
    assign wr_ctrl = cpu_wr & (sel == REG_CTRL);
    assign wr_stat = cpu_wr & (sel == REG_STAT);
    assign wr_data = cpu_wr & (sel == REG_DATA);

    spi_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .wr_stat  (wr_stat),
        .wdata    (cpu_wdata),
        .ctrl_q   (ctrl_q),
        .cfg_q    (cfg_q),
        .part_rst (part_rst)
    );

    spi_rx_flags u_rx (
        .clk      (clk),
        .rst      (rst),
        .part_rst (part_rst),
        .rd_stat  (rd_stat),
        .rd_data  (rd_data),
        .rx_done  (rx_done),
        .rx_byte  (rx_byte),
        .rxf      (flg.rxf),
        .ovr      (flg.ovr),
        .rx_data  (rx_data)
    );

    assign mode_chk = ctrl_q.enable & ctrl_q.master & cfg_q.mfen;

    spi_fault_tx u_ftx (
        .clk      (clk),
        .rst      (rst),
        .part_rst (part_rst),
        .mode_chk (mode_chk),
        .ss_n     (ss_n),
        .rd_stat  (rd_stat),
        .wr_ctrl  (wr_ctrl),
        .wr_data  (wr_data),
        .tx_load  (tx_load),
        .wdata    (cpu_wdata),
        .modf     (flg.modf),
        .txe      (flg.txe),
        .tx_byte  (tx_byte)
    );

    always_comb begin
        unique case (sel)
            REG_CTRL: cpu_rdata = pack_ctrl(ctrl_q);
            REG_STAT: cpu_rdata = pack_status(flg, cfg_q);
            REG_DATA: cpu_rdata = rx_data;
            default:  cpu_rdata = '0;
        endcase
    end

    assign baud_sel = cfg_q.baud;
    assign irq = (flg.rxf & ctrl_q.rxie) | (flg.txe & ctrl_q.txie)
               | ((flg.ovr | flg.modf) & cfg_q.errie);
endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_rd,
    input logic [1:0] cpu_addr,
    input logic       rx_done,
    input logic       wr_ctrl,
    input logic       part_rst,
    input logic       mode_chk,
    input logic       ss_n,
    input logic       en,
    input logic       rxie,
    input logic       txie,
    input logic       errie,
    input logic       rxf,
    input logic       ovr,
    input logic       modf,
    input logic       txe,
    input logic       irq
);
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!rxf && !ovr && !modf && txe && !irq));

    p_rxf_from_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rxf) |-> $past(rx_done));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> ($past(rxf) && $past(rx_done)));

    p_rxf_clear_path_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(rxf) |-> ($past(cpu_rd && cpu_addr == 2'd2) || !en));

    p_modf_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_chk && !ss_n && !part_rst) |=> modf);

    p_modf_clear_path_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(modf) |-> ($past(wr_ctrl) || !en));

    p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !(rxf && rxie) && !(txe && txie)) |-> errie);

    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!rxf && !ovr && !modf && txe));
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_rd   (cpu_rd),
    .cpu_addr (cpu_addr),
    .rx_done  (rx_done),
    .wr_ctrl  (wr_ctrl),
    .part_rst (part_rst),
    .mode_chk (mode_chk),
    .ss_n     (ss_n),
    .en       (ctrl_q.enable),
    .rxie     (ctrl_q.rxie),
    .txie     (ctrl_q.txie),
    .errie    (cfg_q.errie),
    .rxf      (flg.rxf),
    .ovr      (flg.ovr),
    .modf     (flg.modf),
    .txe      (flg.txe),
    .irq      (irq)
);

// File: tb/spi_flag_ctrl_test.sv
module spi_flag_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cpu_addr = 2'd1;
    logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       rx_done = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_load = 1'b0;
    logic [7:0] tx_byte;
    logic       ss_n = 1'b1;
    logic [1:0] baud_sel;
    logic       irq;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flag_ctrl uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rx_done(rx_done), .rx_byte(rx_byte),
        .tx_load(tx_load), .tx_byte(tx_byte), .ss_n(ss_n), .baud_sel(baud_sel), .irq(irq)
    );

    // {rd, wr, addr[1:0], wdata[7:0], rxd, rxb[7:0], txl, ssn, exp_status[7:0], exp_irq}
    function automatic logic [31:0] v(logic rd, logic wr, logic [1:0] a, logic [7:0] wd,
                                      logic rxd, logic [7:0] rxb, logic txl, logic ssn,
                                      logic [7:0] est, logic eirq);
        return {rd, wr, a, wd, rxd, rxb, txl, ssn, est, eirq};
    endfunction

    localparam logic [31:0] VEC [NVEC] = '{
        v(0,1,0,8'h0F,0,8'h00,0,1,8'h08,1), // R9 enable, master, both irq enables
        v(0,1,1,8'hFF,0,8'h00,0,1,8'h4F,1), // R6 read-only bits ignored
        v(0,1,2,8'hA5,0,8'h00,0,1,8'h47,0), // R5 data write clears empty
        v(0,0,0,8'h00,0,8'h00,1,1,8'h4F,1), // R5 tx_load sets empty
        v(0,1,0,8'h07,0,8'h00,0,1,8'h4F,0), // R9 tx irq gated off
        v(0,0,0,8'h00,1,8'h3C,0,1,8'hCF,1), // R2 byte received
        v(0,0,0,8'h00,1,8'h99,0,1,8'hEF,1), // R3 overflow
        v(1,0,1,8'h00,0,8'h00,0,1,8'hEF,1), // R4 arm status read
        v(1,0,2,8'h00,0,8'h00,0,1,8'h4F,0), // R4 data read clears both
        v(0,0,0,8'h00,0,8'h00,0,0,8'h5F,1), // R7 ss low in master
        v(0,1,0,8'h07,0,8'h00,0,1,8'h5F,1), // R8 write without arm
        v(1,0,1,8'h00,0,8'h00,0,1,8'h5F,1), // R8 arm
        v(0,1,0,8'h07,0,8'h00,0,1,8'h4F,0), // R8 clear
        v(0,1,1,8'h08,0,8'h00,0,1,8'h08,0), // R6 detect and error enable off
        v(0,0,0,8'h00,0,8'h00,0,0,8'h08,0), // R7 no fault when detect off
        v(0,0,0,8'h00,1,8'h11,0,1,8'h88,1), // R2 receive, rx irq
        v(1,0,2,8'h00,0,8'h00,0,1,8'h88,1), // R4 data read without arm
        v(0,1,0,8'h06,0,8'h00,0,1,8'h08,0), // R10 partial reset
        v(0,0,0,8'h00,1,8'h22,0,1,8'h08,0), // R10 strobe ignored while off
        v(0,1,0,8'h07,0,8'h00,0,1,8'h08,0)  // R10 re-enable, still idle
    };

    string vtag [NVEC] = '{"R9","R6","R5","R5","R9","R2","R3","R4","R4","R7",
                           "R8","R8","R8","R6","R7","R2","R4","R10","R10","R10"};

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic go_idle();
        cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = 2'd1;
        rx_done = 1'b0; tx_load = 1'b0;
    endtask

    // drive at negedge, let one edge pass, return to idle status view
    task automatic step(logic rd, logic wr, logic [1:0] a, logic [7:0] wd,
                        logic rxd, logic [7:0] rxb, logic txl);
        @(negedge clk);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
        rx_done = rxd; rx_byte = rxb; tx_load = txl;
        @(posedge clk);
        #1 go_idle();
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "status", cpu_rdata, 8'h08);
        chk("R1", "irq", {7'd0, irq}, 8'h00);
        chk("R1", "baud", {6'd0, baud_sel}, 8'h00);
        cpu_addr = 2'd0; #1;
        chk("R1", "control", cpu_rdata, 8'h00);
        cpu_addr = 2'd1; #1;

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] e;
            e = VEC[i];
            ss_n = e[9];
            step(e[31], e[30], e[29:28], e[27:20], e[19], e[18:11], e[10]);
            chk(vtag[i], $sformatf("vec %0d status", i), cpu_rdata, e[8:1]);
            chk(vtag[i], $sformatf("vec %0d irq", i), {7'd0, irq}, {7'd0, e[0]});
        end
        ss_n = 1'b1;

        // R11 completing read collides with a new byte
        step(0,0,0,8'h00,1,8'h5A,0);
        step(1,0,1,8'h00,0,8'h00,0);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 2'd2; rx_done = 1'b1; rx_byte = 8'h6B;
        #1 chk("R11", "data during collision", cpu_rdata, 8'h5A);
        @(posedge clk);
        #1 go_idle(); #1;
        chk("R11", "status after collision", cpu_rdata, 8'h88);
        step(1,0,1,8'h00,0,8'h00,0);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 2'd2;
        #1 chk("R11", "new byte stored", cpu_rdata, 8'h6B);
        @(posedge clk);
        #1 go_idle(); #1;
        chk("R4", "cleared after sequence", cpu_rdata, 8'h08);

        // R3 receive register keeps the earlier byte
        step(0,0,0,8'h00,1,8'h01,0);
        step(0,0,0,8'h00,1,8'h02,0);
        chk("R3", "overflow status", cpu_rdata, 8'hA8);
        step(1,0,1,8'h00,0,8'h00,0);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 2'd2;
        #1 chk("R3", "kept byte", cpu_rdata, 8'h01);
        @(posedge clk);
        #1 go_idle(); #1;

        // R8 fault still present keeps the flag
        step(0,1,1,8'h04,0,8'h00,0);
        ss_n = 1'b0;
        step(0,0,0,8'h00,0,8'h00,0);
        chk("R7", "fault set", cpu_rdata, 8'h1C);
        step(1,0,1,8'h00,0,8'h00,0);
        step(0,1,0,8'h07,0,8'h00,0);
        chk("R8", "fault persists", cpu_rdata, 8'h1C);
        ss_n = 1'b1;
        step(1,0,1,8'h00,0,8'h00,0);
        step(0,1,0,8'h07,0,8'h00,0);
        chk("R8", "fault cleared", cpu_rdata, 8'h0C);

        // R6 baud output
        step(0,1,1,8'h02,0,8'h00,0);
        chk("R6", "baud_sel", {6'd0, baud_sel}, 8'h02);

        // R5 transmit byte output
        step(0,1,2,8'hC3,0,8'h00,0);
        chk("R5", "tx_byte", tx_byte, 8'hC3);

        // R10 configuration survives a partial reset
        step(0,1,0,8'h0C,0,8'h00,0);
        cpu_addr = 2'd0; #1;
        chk("R10", "control kept", cpu_rdata, 8'h0C);
        cpu_addr = 2'd1; #1;
        chk("R10", "status idle, baud kept", cpu_rdata, 8'h0A);
        chk("R9", "tx irq while disabled", {7'd0, irq}, 8'h01);
        step(0,1,2,8'h77,0,8'h00,0);
        chk("R10", "data write ignored", tx_byte, 8'hC3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule